// File: doc/BRIEF.md
# AXI Write Permission Gate

This block sits on the write address, write data and write response channels between an AXI4 master and an AXI4 slave. A single permission input, sampled when a write address is offered, decides whether that write may reach memory. While permission is granted, every handshake and payload field passes straight through with no added register stage.

When a write is refused, the block takes over the master side of all three channels. It completes the address handshake itself and accepts every data beat up to and including the one marked last, discarding the data. It then returns a decode-error write response tagged with the refused request's ID. The slave never sees a valid address or data beat for a refused write. A system uses the block to fence off a DMA-capable master: an external range checker computes the permission flag from the requested address and length.

Top module: `axi_wr_gate`

## Requirements
- R1: In the idle (forwarding) state with `allow_wr` high, `m_awvalid`, `m_wvalid` and the payload fields equal the master-side inputs, and `s_awready`/`s_wready` equal the slave-side ready inputs in the same cycle. The slave's B channel appears unchanged at `s_bid`, `s_bresp` and `s_bvalid`.
- R2: For a refused write, `m_awvalid` and `m_wvalid` stay low in every cycle from the refused offer until the block has returned to the forwarding state.
- R3: `s_awvalid` high with `allow_wr` low in the forwarding state makes `s_awready` high in the next cycle. One cycle after that handshake, `s_awready` is low again.
- R4: After the refused address handshake, `s_wready` stays high, including cycles with `s_wvalid` low. Beats are consumed until one has `s_wvalid` and `s_wlast` high. In the cycle after that beat, `s_wready` is low.
- R5: In the cycle after the last refused beat, `s_bvalid` is low. From the next cycle on, `s_bvalid` is high with `s_bresp` = 2'b11 (DECERR). Both are held until `s_bready` is sampled high. The cycle after that, the block is back in forwarding.
- R6: The injected response carries on `s_bid` the `s_awid` of the refused request.
- R7: `m_bready` always equals `s_bready`. While the block drives its own response, the slave's `m_bvalid`, `m_bresp` and `m_bid` have no effect on `s_bvalid`, `s_bresp` or `s_bid`.
- R8: Reset is synchronous and active low. It returns the block to forwarding with its own AWREADY, WREADY and BVALID low, even in the middle of a refused burst.
- R9: Changes of `allow_wr` after a write has been refused do not let any beat through to the slave or alter the refused sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| allow_wr | input | 1 | Permission for the write address currently offered |
| s_awid | input | ID_W | Master write address ID |
| s_awaddr | input | ADDR_W | Master write address |
| s_awlen | input | 8 | Master burst length minus one |
| s_awsize | input | 3 | Master beat size |
| s_awburst | input | 2 | Master burst type |
| s_awprot | input | 3 | Master protection attributes |
| s_awuser | input | USER_W | Master address user bits |
| s_awvalid | input | 1 | Master address valid |
| s_awready | output | 1 | Address ready to master |
| s_wdata | input | DATA_W | Master write data |
| s_wstrb | input | DATA_W/8 | Master byte strobes |
| s_wlast | input | 1 | Master last beat flag |
| s_wuser | input | USER_W | Master data user bits |
| s_wvalid | input | 1 | Master data valid |
| s_wready | output | 1 | Data ready to master |
| s_bid | output | ID_W | Response ID to master |
| s_bresp | output | 2 | Response code to master |
| s_buser | output | USER_W | Response user bits to master |
| s_bvalid | output | 1 | Response valid to master |
| s_bready | input | 1 | Master response ready |
| m_awid | output | ID_W | Address ID to slave |
| m_awaddr | output | ADDR_W | Address to slave |
| m_awlen | output | 8 | Burst length to slave |
| m_awsize | output | 3 | Beat size to slave |
| m_awburst | output | 2 | Burst type to slave |
| m_awprot | output | 3 | Protection attributes to slave |
| m_awuser | output | USER_W | Address user bits to slave |
| m_awvalid | output | 1 | Address valid to slave |
| m_awready | input | 1 | Slave address ready |
| m_wdata | output | DATA_W | Write data to slave |
| m_wstrb | output | DATA_W/8 | Byte strobes to slave |
| m_wlast | output | 1 | Last beat flag to slave |
| m_wuser | output | USER_W | Data user bits to slave |
| m_wvalid | output | 1 | Data valid to slave |
| m_wready | input | 1 | Slave data ready |
| m_bid | input | ID_W | Slave response ID |
| m_bresp | input | 2 | Slave response code |
| m_buser | input | USER_W | Slave response user bits |
| m_bvalid | input | 1 | Slave response valid |
| m_bready | output | 1 | Response ready to slave |

## Verification
Two functions can meet in one cycle. The block sinks the refused address while the master is already presenting the first, possibly last, data beat, and it then absorbs that beat. The bench provokes this by raising `s_wvalid` and `s_wlast` in the same cycle as the refused `s_awvalid` for single-beat bursts. It judges the outcome by `s_wready` staying low until the address handshake has completed, by exactly one extra cycle before the response, and by `m_wvalid` never rising. The slave side also offers a conflicting response and flips `allow_wr` during the sink, to show that neither leaks into the injected reply.

// File: rtl/wg_pkg.sv
package wg_pkg;

  // Controller states; the ordering carries no meaning outside this block.
  typedef enum logic [1:0] {
    ST_FWD   = 2'b00,  // traffic passes through
    ST_ADDR  = 2'b01,  // refused address being accepted locally
    ST_DRAIN = 2'b10,  // refused data beats being discarded
    ST_RESP  = 2'b11   // local error response being offered
  } wg_state_e;

  localparam logic [1:0] RSP_OKAY   = 2'b00;
  localparam logic [1:0] RSP_DECERR = 2'b11;

  // Handshakes are routed to the slave only when idle and permitted.
  function automatic logic path_open(input wg_state_e st, input logic allow);
    return (st == ST_FWD) && allow;
  endfunction

  // The response channel is taken over only while a local reply is due.
  function automatic logic reply_local(input wg_state_e st);
    return st == ST_RESP;
  endfunction

  // A refusal starts when an address is offered without permission.
  function automatic logic refuse_now(input wg_state_e st, input logic allow,
                                      input logic awvalid);
    return (st == ST_FWD) && !allow && awvalid;
  endfunction

endpackage

// File: rtl/wg_ctrl.sv
module wg_ctrl
  import wg_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            allow,
  input  logic [ID_W-1:0] s_awid,
  input  logic            s_awvalid,
  input  logic            s_wvalid,
  input  logic            s_wlast,
  input  logic            s_bready,
  output wg_state_e       st,
  output logic            loc_awready,
  output logic            loc_wready,
  output logic            loc_bvalid,
  output logic [1:0]      loc_bresp,
  output logic [ID_W-1:0] loc_bid
);

  // Named events, visible to the assertions below.
  logic ev_refuse;
  logic ev_addr_taken;
  logic ev_last_sunk;
  logic ev_reply_done;

  assign ev_refuse     = refuse_now(st, allow, s_awvalid);
  assign ev_addr_taken = (st == ST_ADDR) && loc_awready && s_awvalid;
  assign ev_last_sunk  = (st == ST_DRAIN) && loc_wready && s_wvalid && s_wlast;
  assign ev_reply_done = (st == ST_RESP) && loc_bvalid && s_bready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_FWD;
      loc_awready <= 1'b0;
      loc_wready  <= 1'b0;
      loc_bvalid  <= 1'b0;
      loc_bresp   <= RSP_OKAY;
      loc_bid     <= '0;
    end else begin
      case (st)
        ST_FWD: begin
          if (ev_refuse) begin
            loc_awready <= 1'b1;
            loc_bid     <= s_awid;
            st          <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (ev_addr_taken) begin
            loc_awready <= 1'b0;
            loc_wready  <= 1'b1;
            st          <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (ev_last_sunk) begin
            loc_wready <= 1'b0;
            loc_bvalid <= 1'b0;
            st         <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (!loc_bvalid) begin
            loc_bvalid <= 1'b1;
            loc_bresp  <= RSP_DECERR;
          end else if (ev_reply_done) begin
            loc_bvalid <= 1'b0;
            loc_bresp  <= RSP_OKAY;
            st         <= ST_FWD;
          end
        end
        default: st <= ST_FWD;
      endcase
    end
  end

  // R3: a refused offer is answered by a local address ready next cycle
  a_r3_refuse_takes_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refuse |=> (st == ST_ADDR) && loc_awready);

  // R3: the local address ready is withdrawn after its handshake
  a_r3_addr_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_taken |=> !loc_awready && (st == ST_DRAIN));

  // R4: data is always accepted while draining
  a_r4_drain_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DRAIN) |-> loc_wready);

  // R4: the last beat ends the drain
  a_r4_last_ends_drain: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last_sunk |=> (st == ST_RESP) && !loc_wready && !loc_bvalid);

  // R5: an unaccepted local response is held with its ID
  a_r5_reply_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_RESP) && loc_bvalid && !s_bready) |=> loc_bvalid && $stable(loc_bid));

  // R5: once accepted, the block is idle again
  a_r5_reply_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reply_done |=> (st == ST_FWD) && !loc_bvalid);

  // R6: the reply ID is the refused request's ID
  a_r6_bid_captured: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refuse |=> loc_bid == $past(s_awid));

  // R8: at most one locally driven handshake is active at a time
  a_r8_local_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({loc_awready, loc_wready, loc_bvalid}));

endmodule

// File: rtl/wg_route.sv
module wg_route
  import wg_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int USER_W = 2
) (
  input  wg_state_e         st,
  input  logic              allow,
  input  logic              loc_awready,
  input  logic              loc_wready,
  input  logic              loc_bvalid,
  input  logic [1:0]        loc_bresp,
  input  logic [ID_W-1:0]   loc_bid,
  input  logic [ID_W-1:0]   s_awid,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [7:0]        s_awlen,
  input  logic [2:0]        s_awsize,
  input  logic [1:0]        s_awburst,
  input  logic [2:0]        s_awprot,
  input  logic [USER_W-1:0] s_awuser,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic              s_wlast,
  input  logic [USER_W-1:0] s_wuser,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [ID_W-1:0]   s_bid,
  output logic [1:0]        s_bresp,
  output logic [USER_W-1:0] s_buser,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [ID_W-1:0]   m_awid,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [7:0]        m_awlen,
  output logic [2:0]        m_awsize,
  output logic [1:0]        m_awburst,
  output logic [2:0]        m_awprot,
  output logic [USER_W-1:0] m_awuser,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic              m_wlast,
  output logic [USER_W-1:0] m_wuser,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [ID_W-1:0]   m_bid,
  input  logic [1:0]        m_bresp,
  input  logic [USER_W-1:0] m_buser,
  input  logic              m_bvalid,
  output logic              m_bready
);

  logic open_path;
  logic own_reply;

  assign open_path = path_open(st, allow);
  assign own_reply = reply_local(st);

  // Payload fields always flow through unchanged.
  assign m_awid    = s_awid;
  assign m_awaddr  = s_awaddr;
  assign m_awlen   = s_awlen;
  assign m_awsize  = s_awsize;
  assign m_awburst = s_awburst;
  assign m_awprot  = s_awprot;
  assign m_awuser  = s_awuser;
  assign m_wdata   = s_wdata;
  assign m_wstrb   = s_wstrb;
  assign m_wlast   = s_wlast;
  assign m_wuser   = s_wuser;
  assign s_buser   = m_buser;
  assign m_bready  = s_bready;

  // The block never offers anything of its own to the slave.
  assign m_awvalid = open_path ? s_awvalid : 1'b0;
  assign m_wvalid  = open_path ? s_wvalid  : 1'b0;
  assign s_awready = open_path ? m_awready : loc_awready;
  assign s_wready  = open_path ? m_wready  : loc_wready;

  assign s_bvalid  = own_reply ? loc_bvalid : m_bvalid;
  assign s_bresp   = own_reply ? loc_bresp  : m_bresp;
  assign s_bid     = own_reply ? loc_bid    : m_bid;

endmodule

// File: rtl/axi_wr_gate.sv
module axi_wr_gate
  import wg_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int USER_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                allow_wr,
  input  logic [ID_W-1:0]     s_awid,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic [7:0]          s_awlen,
  input  logic [2:0]          s_awsize,
  input  logic [1:0]          s_awburst,
  input  logic [2:0]          s_awprot,
  input  logic [USER_W-1:0]   s_awuser,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wlast,
  input  logic [USER_W-1:0]   s_wuser,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [ID_W-1:0]     s_bid,
  output logic [1:0]          s_bresp,
  output logic [USER_W-1:0]   s_buser,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [ID_W-1:0]     m_awid,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic [2:0]          m_awprot,
  output logic [USER_W-1:0]   m_awuser,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  output logic [USER_W-1:0]   m_wuser,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [ID_W-1:0]     m_bid,
  input  logic [1:0]          m_bresp,
  input  logic [USER_W-1:0]   m_buser,
  input  logic                m_bvalid,
  output logic                m_bready
);

  wg_state_e       st;
  logic            loc_awready;
  logic            loc_wready;
  logic            loc_bvalid;
  logic [1:0]      loc_bresp;
  logic [ID_W-1:0] loc_bid;

  wg_ctrl #(.ID_W(ID_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .allow       (allow_wr),
    .s_awid      (s_awid),
    .s_awvalid   (s_awvalid),
    .s_wvalid    (s_wvalid),
    .s_wlast     (s_wlast),
    .s_bready    (s_bready),
    .st          (st),
    .loc_awready (loc_awready),
    .loc_wready  (loc_wready),
    .loc_bvalid  (loc_bvalid),
    .loc_bresp   (loc_bresp),
    .loc_bid     (loc_bid)
  );

  wg_route #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .USER_W(USER_W)
  ) u_route (
    .st          (st),
    .allow       (allow_wr),
    .loc_awready (loc_awready),
    .loc_wready  (loc_wready),
    .loc_bvalid  (loc_bvalid),
    .loc_bresp   (loc_bresp),
    .loc_bid     (loc_bid),
    .s_awid      (s_awid),
    .s_awaddr    (s_awaddr),
    .s_awlen     (s_awlen),
    .s_awsize    (s_awsize),
    .s_awburst   (s_awburst),
    .s_awprot    (s_awprot),
    .s_awuser    (s_awuser),
    .s_awvalid   (s_awvalid),
    .s_awready   (s_awready),
    .s_wdata     (s_wdata),
    .s_wstrb     (s_wstrb),
    .s_wlast     (s_wlast),
    .s_wuser     (s_wuser),
    .s_wvalid    (s_wvalid),
    .s_wready    (s_wready),
    .s_bid       (s_bid),
    .s_bresp     (s_bresp),
    .s_buser     (s_buser),
    .s_bvalid    (s_bvalid),
    .s_bready    (s_bready),
    .m_awid      (m_awid),
    .m_awaddr    (m_awaddr),
    .m_awlen     (m_awlen),
    .m_awsize    (m_awsize),
    .m_awburst   (m_awburst),
    .m_awprot    (m_awprot),
    .m_awuser    (m_awuser),
    .m_awvalid   (m_awvalid),
    .m_awready   (m_awready),
    .m_wdata     (m_wdata),
    .m_wstrb     (m_wstrb),
    .m_wlast     (m_wlast),
    .m_wuser     (m_wuser),
    .m_wvalid    (m_wvalid),
    .m_wready    (m_wready),
    .m_bid       (m_bid),
    .m_bresp     (m_bresp),
    .m_buser     (m_buser),
    .m_bvalid    (m_bvalid),
    .m_bready    (m_bready)
  );

  // R2, R9: outside forwarding nothing is offered to the slave
  a_r2_no_leak: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_FWD) |-> (!m_awvalid && !m_wvalid));

  // R5: a response seen by the master during the local reply is DECERR
  a_r5_decerr_code: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && (st == ST_RESP)) |-> (s_bresp == RSP_DECERR));

  // R7: the slave's response valid cannot reach the master during the local reply
  a_r7_slave_b_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_RESP) && !loc_bvalid) |-> !s_bvalid);

endmodule

// File: tb/sim_axi_wr_gate.sv
module sim_axi_wr_gate;

  localparam int CLK_P  = 10;
  localparam int ID_W   = 4;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int USER_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic allow_wr = 1'b0;
  logic [ID_W-1:0] s_awid = '0;
  logic [ADDR_W-1:0] s_awaddr = '0;
  logic [7:0] s_awlen = '0;
  logic [2:0] s_awsize = 3'd2;
  logic [1:0] s_awburst = 2'b01;
  logic [2:0] s_awprot = '0;
  logic [USER_W-1:0] s_awuser = '0;
  logic s_awvalid = 1'b0;
  logic s_awready;
  logic [DATA_W-1:0] s_wdata = '0;
  logic [DATA_W/8-1:0] s_wstrb = '1;
  logic s_wlast = 1'b0;
  logic [USER_W-1:0] s_wuser = '0;
  logic s_wvalid = 1'b0;
  logic s_wready;
  logic [ID_W-1:0] s_bid;
  logic [1:0] s_bresp;
  logic [USER_W-1:0] s_buser;
  logic s_bvalid;
  logic s_bready = 1'b0;
  logic [ID_W-1:0] m_awid;
  logic [ADDR_W-1:0] m_awaddr;
  logic [7:0] m_awlen;
  logic [2:0] m_awsize;
  logic [1:0] m_awburst;
  logic [2:0] m_awprot;
  logic [USER_W-1:0] m_awuser;
  logic m_awvalid;
  logic m_awready = 1'b0;
  logic [DATA_W-1:0] m_wdata;
  logic [DATA_W/8-1:0] m_wstrb;
  logic m_wlast;
  logic [USER_W-1:0] m_wuser;
  logic m_wvalid;
  logic m_wready = 1'b0;
  logic [ID_W-1:0] m_bid = '0;
  logic [1:0] m_bresp = '0;
  logic [USER_W-1:0] m_buser = '0;
  logic m_bvalid = 1'b0;
  logic m_bready;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  axi_wr_gate #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .USER_W(USER_W)) u0 (
    .clk(clk), .rst_n(rst_n), .allow_wr(allow_wr),
    .s_awid(s_awid), .s_awaddr(s_awaddr), .s_awlen(s_awlen), .s_awsize(s_awsize),
    .s_awburst(s_awburst), .s_awprot(s_awprot), .s_awuser(s_awuser),
    .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wlast(s_wlast), .s_wuser(s_wuser),
    .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bid(s_bid), .s_bresp(s_bresp), .s_buser(s_buser), .s_bvalid(s_bvalid),
    .s_bready(s_bready),
    .m_awid(m_awid), .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
    .m_awburst(m_awburst), .m_awprot(m_awprot), .m_awuser(m_awuser),
    .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wuser(m_wuser),
    .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bid(m_bid), .m_bresp(m_bresp), .m_buser(m_buser), .m_bvalid(m_bvalid),
    .m_bready(m_bready)
  );

  // Expected values from the requirements
  function automatic logic [1:0] exp_refused_code();
    return 2'b11;  // DECERR
  endfunction

  function automatic logic exp_pass_ready(input logic allowed, input logic slave_rdy);
    return allowed ? slave_rdy : 1'b0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // Forwarded write with random slave stalls
  task automatic fwd_write(input int beats);
    logic [ID_W-1:0] id;
    bit acc;
    @(negedge clk);
    id = ID_W'($urandom);
    allow_wr = 1'b1;
    s_awid = id;
    s_awaddr = $urandom;
    s_awlen = 8'(beats - 1);
    s_awvalid = 1'b1;
    do begin
      m_awready = 1'($urandom);
      #1;
      chk("R1 awvalid", m_awvalid, 1'b1);
      chk("R1 awaddr", m_awaddr, s_awaddr);
      chk("R1 awid", m_awid, id);
      chk("R1 awready", s_awready, exp_pass_ready(1'b1, m_awready));
      acc = m_awready;
      @(negedge clk);
    end while (!acc);
    s_awvalid = 1'b0;
    m_awready = 1'b0;
    for (int sent = 0; sent < beats; ) begin
      s_wvalid = 1'b1;
      s_wdata = $urandom;
      s_wlast = (sent == beats - 1);
      m_wready = 1'($urandom);
      #1;
      chk("R1 wvalid", m_wvalid, 1'b1);
      chk("R1 wdata", m_wdata, s_wdata);
      chk("R1 wlast", m_wlast, s_wlast);
      chk("R1 wready", s_wready, m_wready);
      if (m_wready) sent++;
      @(negedge clk);
    end
    s_wvalid = 1'b0;
    s_wlast = 1'b0;
    m_wready = 1'b0;
    m_bvalid = 1'b1;
    m_bresp = ($urandom % 2) ? 2'b10 : 2'b00;
    m_bid = id;
    s_bready = 1'b1;
    #1;
    chk("R1 bvalid", s_bvalid, 1'b1);
    chk("R1 bresp", s_bresp, m_bresp);
    chk("R1 bid", s_bid, id);
    chk("R7 bready", m_bready, 1'b1);
    @(negedge clk);
    m_bvalid = 1'b0;
    s_bready = 1'b0;
  endtask

  // Refused write; early_w presents the first beat together with the address
  task automatic deny_write(input int beats, input int hold, input bit early_w,
                            input bit flip_allow);
    logic [ID_W-1:0] id;
    @(negedge clk);
    id = ID_W'($urandom);
    allow_wr = 1'b0;
    s_awid = id;
    s_awaddr = $urandom;
    s_awlen = 8'(beats - 1);
    s_awvalid = 1'b1;
    m_awready = 1'b1;
    m_wready = 1'b1;
    if (early_w) begin
      s_wvalid = 1'b1;
      s_wlast = (beats == 1);
      s_wdata = $urandom;
    end
    #1;
    chk("R2 awvalid at offer", m_awvalid, 1'b0);
    chk("R3 awready at offer", s_awready, 1'b0);
    @(negedge clk);
    chk("R3 local awready", s_awready, 1'b1);
    chk("R2 awvalid in addr", m_awvalid, 1'b0);
    chk("R2 wvalid in addr", m_wvalid, 1'b0);
    chk("R4 wready before addr done", s_wready, 1'b0);
    if (flip_allow) allow_wr = 1'b1;
    #1;
    chk("R9 awvalid with allow flipped", m_awvalid, 1'b0);
    @(negedge clk);
    s_awvalid = 1'b0;
    chk("R3 awready dropped", s_awready, 1'b0);
    for (int sent = 0; sent < beats; ) begin
      if (flip_allow) allow_wr = 1'($urandom);
      if (($urandom % 4) == 0) begin
        s_wvalid = 1'b0;
        s_wlast = 1'b0;
      end else begin
        s_wvalid = 1'b1;
        s_wdata = $urandom;
        s_wlast = (sent == beats - 1);
      end
      #1;
      chk("R4 wready in drain", s_wready, 1'b1);
      chk("R2 wvalid in drain", m_wvalid, 1'b0);
      chk("R9 awvalid in drain", m_awvalid, 1'b0);
      if (s_wvalid) sent++;
      @(negedge clk);
    end
    s_wvalid = 1'b0;
    s_wlast = 1'b0;
    m_bvalid = 1'b1;
    m_bresp = 2'b00;
    m_bid = ~id;
    #1;
    chk("R4 wready after last", s_wready, 1'b0);
    chk("R5 bvalid gap", s_bvalid, 1'b0);
    chk("R7 slave b masked", s_bvalid, 1'b0);
    @(negedge clk);
    for (int k = 0; k < hold; k++) begin
      if (flip_allow) allow_wr = 1'($urandom);
      #1;
      chk("R5 bvalid held", s_bvalid, 1'b1);
      chk("R5 bresp", s_bresp, exp_refused_code());
      chk("R6 bid", s_bid, id);
      chk("R2 awvalid in resp", m_awvalid, 1'b0);
      @(negedge clk);
    end
    s_bready = 1'b1;
    #1;
    chk("R5 bvalid", s_bvalid, 1'b1);
    chk("R5 bresp final", s_bresp, exp_refused_code());
    chk("R6 bid final", s_bid, id);
    chk("R7 bready", m_bready, 1'b1);
    @(negedge clk);
    m_bvalid = 1'b0;
    s_bready = 1'b0;
    allow_wr = 1'b1;
    m_awready = 1'b0;
    #1;
    chk("R5 bvalid cleared", s_bvalid, 1'b0);
    chk("R5 back to forwarding", s_awready, 1'b0);
    m_awready = 1'b1;
    #1;
    chk("R5 back to forwarding ready", s_awready, 1'b1);
    m_awready = 1'b0;
    m_wready = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 awready in reset", s_awready, 1'b0);
    chk("R8 wready in reset", s_wready, 1'b0);
    chk("R8 bvalid in reset", s_bvalid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle awready", s_awready, 1'b0);
    chk("R8 idle bvalid", s_bvalid, 1'b0);

    fwd_write(1);
    deny_write(1, 0, 1'b1, 1'b0);  // address and last beat together
    deny_write(4, 3, 1'b0, 1'b1);
    fwd_write(3);
    deny_write(1, 2, 1'b1, 1'b1);

    // R8: reset in the middle of a refused burst
    @(negedge clk);
    allow_wr = 1'b0;
    s_awid = 4'h5;
    s_awvalid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    s_awvalid = 1'b0;
    chk("R8 draining before reset", s_wready, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    allow_wr = 1'b1;
    m_awready = 1'b1;
    m_wready = 1'b0;
    #1;
    chk("R8 wready after mid reset", s_wready, 1'b0);
    chk("R8 forwarding after mid reset", s_awready, 1'b1);
    chk("R8 bvalid after mid reset", s_bvalid, 1'b0);
    m_awready = 1'b0;

    for (int i = 0; i < 40; i++) begin
      if ($urandom % 2)
        fwd_write(1 + ($urandom % 5));
      else
        deny_write(1 + ($urandom % 6), $urandom % 4, 1'($urandom), 1'($urandom));
    end
    @(negedge clk);
    finish_run();
  end

endmodule